// File: doc/BRIEF.md
# Vectored Interrupt Front End

This block sits beside the pipeline of a small 32-bit processor and takes in up to 32 external interrupt request lines. A line held high at a clock edge sets its bit in a sticky pending register. The bit stays set until software clears it, even after the line has dropped. A mask register selects which pending bits may interrupt. A two-bit enable register holds a live enable in bit 0 and a saved copy in bit 1. A fourth register holds the exception base address. Software reaches all four through a small select/write/read register port.

The core raises `boundary_i` in each cycle in which an instruction has just completed. In such a cycle the block decides, combinationally, whether to take an interrupt. When it does, it returns the address the core saves into its exception-address register (the current PC) and the vector target (base plus exception ID times 32). At the next edge it rewrites the enable register to binary 10, so the old enable is parked in bit 1 and interrupts are turned off.

The decision is only evaluated while a check is armed. Any high request line arms the check for the following cycle, and the check stays armed until a boundary cycle consumes it. A held line therefore makes the block re-evaluate at every boundary, so that a later mask or enable write can release the waiting interrupt. A return strobe copies the saved enable back into the live enable.

Top module: `vec_irq_unit`

## Requirements
- R1: After reset the pending, mask, enable and base registers all read zero and `take_irq_o` is 0.
- R2: A request line n that is high at a clock edge sets pending bit n, which reads 1 from the next cycle on. A line returning low never clears a pending bit.
- R3: A write with select 0 (pending) clears every pending bit written as 1 and leaves bits written as 0 alone. A bit whose line is still high reads 1 after the clearing write.
- R4: `take_irq_o` is 1 only in a cycle with `boundary_i` high, enable bit 0 set, a nonzero AND of mask and pending, and an armed check. It is 0 whenever any of these is missing.
- R5: While `take_irq_o` is 1, `vector_pc_o` equals base + EXC_ID*32 (default EXC_ID 6, offset 192) and `save_pc_o` equals `pc_i`. While it is 0, both outputs are zero.
- R6: The edge after a taken interrupt leaves the enable register at binary 10. The take wins over a register write to the enable register in the same cycle.
- R7: `eret_i` (with no take in the same cycle) copies enable bit 1 into bit 0 and keeps bit 1. It wins over a register write to the enable register in the same cycle.
- R8: A request line high in a cycle arms the check for the next cycle. The check stays armed until a boundary cycle. So a mask write made while a line is held high lets the interrupt be taken at the next boundary.
- R9: Once a boundary cycle has consumed the check and no line has been high since, a pending bit that later becomes unmasked is not taken.
- R10: The register select encodes pending=0, mask=1, enable=2, base=3. Mask is read/write over NLINES bits. Enable is read/write over bits 1:0. Base bits below EBA_ALIGN (default 8) read zero and ignore writes. `csr_rdata_o` shows the selected register in the same cycle, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NLINES | External request lines, level sensitive |
| boundary_i | input | 1 | Instruction has completed this cycle |
| pc_i | input | XLEN | Program counter of the interrupted flow |
| eret_i | input | 1 | Return from exception, restores the live enable |
| csr_sel_i | input | 2 | Register select (0 pending, 1 mask, 2 enable, 3 base) |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Selected register read data |
| take_irq_o | output | 1 | Interrupt taken at this boundary |
| vector_pc_o | output | XLEN | Handler address, valid with take |
| save_pc_o | output | XLEN | Address to save into the exception-address register, valid with take |

## Verification
The case that is hardest to reach is a pending bit whose line has already dropped and whose check has already been spent at a boundary. Unmasking it must then have no effect, and that state only exists after a pulse, a boundary that did not take, and a mask write in that order. The bench reaches it in every off-diagonal step of a full 32-by-32 sweep of mask bit against pulsed line. The opposite case, a line held high across several boundaries while the mask is opened, is driven separately to show that the re-check releases the interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      CSR_PEND = 2'd0,
      CSR_MASK = 2'd1,
      CSR_ENAB = 2'd2,
      CSR_BASE = 2'd3
   } csr_sel_e;

   localparam int IE_W = 2;
   localparam logic [IE_W-1:0] IE_ON_TAKE = 2'b10;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int NLINES = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NLINES-1:0] lines_i,
   input  logic              clr_we_i,
   input  logic [NLINES-1:0] clr_mask_i,
   input  logic              boundary_i,
   output logic [NLINES-1:0] pend_o,
   output logic              armed_o
);

   logic [NLINES-1:0] pend_q;
   logic              chk_q;

   for (genvar g = 0; g < NLINES; g++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            pend_q[g] <= 1'b0;
         end else begin
            pend_q[g] <= lines_i[g] | (pend_q[g] & ~(clr_we_i & clr_mask_i[g]));
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chk_q <= 1'b0;
      end else begin
         chk_q <= (|lines_i) | (chk_q & ~boundary_i);
      end
   end

   assign pend_o  = pend_q;
   assign armed_o = chk_q;

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
   import irq_pkg::*;
#(
   parameter int NLINES    = 32,
   parameter int XLEN      = 32,
   parameter int EBA_ALIGN = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  csr_sel_e          sel_i,
   input  logic              we_i,
   input  logic [XLEN-1:0]   wdata_i,
   input  logic              take_i,
   input  logic              eret_i,
   output logic [NLINES-1:0] mask_o,
   output logic [IE_W-1:0]   ie_o,
   output logic [XLEN-1:0]   eba_o
);

   logic [NLINES-1:0]         mask_q;
   logic [IE_W-1:0]           ie_q;
   logic [XLEN-1:EBA_ALIGN]   eba_hi_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (we_i && sel_i == CSR_MASK) begin
         mask_q <= wdata_i[NLINES-1:0];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ie_q <= '0;
      end else if (take_i) begin
         ie_q <= IE_ON_TAKE;
      end else if (eret_i) begin
         ie_q <= {ie_q[1], ie_q[1]};
      end else if (we_i && sel_i == CSR_ENAB) begin
         ie_q <= wdata_i[IE_W-1:0];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         eba_hi_q <= '0;
      end else if (we_i && sel_i == CSR_BASE) begin
         eba_hi_q <= wdata_i[XLEN-1:EBA_ALIGN];
      end
   end

   assign mask_o = mask_q;
   assign ie_o   = ie_q;
   assign eba_o  = {eba_hi_q, {EBA_ALIGN{1'b0}}};

endmodule

// File: rtl/irq_decide.sv
module irq_decide #(
   parameter int NLINES    = 32,
   parameter int XLEN      = 32,
   parameter int EXC_ID    = 6,
   parameter int VEC_SHIFT = 5
) (
   input  logic [NLINES-1:0] pend_i,
   input  logic [NLINES-1:0] mask_i,
   input  logic              ie_live_i,
   input  logic              armed_i,
   input  logic              boundary_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   eba_i,
   output logic              take_o,
   output logic [XLEN-1:0]   vector_o,
   output logic [XLEN-1:0]   save_pc_o
);

   localparam logic [XLEN-1:0] VEC_OFF = XLEN'(EXC_ID) << VEC_SHIFT;

   logic hit;

   always_comb begin
      hit       = |(pend_i & mask_i);
      take_o    = boundary_i & armed_i & ie_live_i & hit;
      vector_o  = take_o ? (eba_i + VEC_OFF) : '0;
      save_pc_o = take_o ? pc_i : '0;
   end

endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
   import irq_pkg::*;
#(
   parameter int NLINES    = 32,
   parameter int XLEN      = 32,
   parameter int EXC_ID    = 6,
   parameter int VEC_SHIFT = 5,
   parameter int EBA_ALIGN = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NLINES-1:0] irq_i,
   input  logic              boundary_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              eret_i,
   input  logic [1:0]        csr_sel_i,
   input  logic              csr_we_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   output logic              take_irq_o,
   output logic [XLEN-1:0]   vector_pc_o,
   output logic [XLEN-1:0]   save_pc_o
);

   if (NLINES < 1 || NLINES > XLEN) begin : g_bad_lines
      $error("NLINES must lie in 1..XLEN");
   end
   if (EBA_ALIGN < 1 || EBA_ALIGN > NLINES || EBA_ALIGN >= XLEN) begin : g_bad_align
      $error("EBA_ALIGN must lie in 1..NLINES and below XLEN");
   end
   if ((EXC_ID << VEC_SHIFT) >= (1 << EBA_ALIGN)) begin : g_bad_vec
      $error("vector offset must fit below the base alignment");
   end

   csr_sel_e          sel;
   logic [NLINES-1:0] ip_q;
   logic [NLINES-1:0] im_q;
   logic [IE_W-1:0]   ie_q;
   logic [XLEN-1:0]   eba_q;
   logic              armed;
   logic              take;

   assign sel = csr_sel_e'(csr_sel_i);

   irq_pend #(.NLINES(NLINES)) u_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lines_i    (irq_i),
      .clr_we_i   (csr_we_i && sel == CSR_PEND),
      .clr_mask_i (csr_wdata_i[NLINES-1:0]),
      .boundary_i (boundary_i),
      .pend_o     (ip_q),
      .armed_o    (armed)
   );

   irq_ctl_regs #(
      .NLINES    (NLINES),
      .XLEN      (XLEN),
      .EBA_ALIGN (EBA_ALIGN)
   ) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .we_i    (csr_we_i),
      .wdata_i (csr_wdata_i),
      .take_i  (take),
      .eret_i  (eret_i),
      .mask_o  (im_q),
      .ie_o    (ie_q),
      .eba_o   (eba_q)
   );

   irq_decide #(
      .NLINES    (NLINES),
      .XLEN      (XLEN),
      .EXC_ID    (EXC_ID),
      .VEC_SHIFT (VEC_SHIFT)
   ) u_decide (
      .pend_i     (ip_q),
      .mask_i     (im_q),
      .ie_live_i  (ie_q[0]),
      .armed_i    (armed),
      .boundary_i (boundary_i),
      .pc_i       (pc_i),
      .eba_i      (eba_q),
      .take_o     (take),
      .vector_o   (vector_pc_o),
      .save_pc_o  (save_pc_o)
   );

   assign take_irq_o = take;

   always_comb begin
      csr_rdata_o = '0;
      case (sel)
         CSR_PEND: csr_rdata_o[NLINES-1:0] = ip_q;
         CSR_MASK: csr_rdata_o[NLINES-1:0] = im_q;
         CSR_ENAB: csr_rdata_o[IE_W-1:0]   = ie_q;
         CSR_BASE: csr_rdata_o             = eba_q;
         default:  csr_rdata_o             = '0;
      endcase
   end

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
   parameter int NLINES    = 32,
   parameter int XLEN      = 32,
   parameter int EXC_ID    = 6,
   parameter int VEC_SHIFT = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NLINES-1:0] irq,
   input logic              boundary,
   input logic              eret,
   input logic              take,
   input logic [XLEN-1:0]   vector,
   input logic [XLEN-1:0]   save_pc,
   input logic [XLEN-1:0]   pc,
   input logic [NLINES-1:0] ip,
   input logic [NLINES-1:0] im,
   input logic [1:0]        ie,
   input logic [XLEN-1:0]   eba
);

   localparam logic [XLEN-1:0] OFF = XLEN'(EXC_ID) << VEC_SHIFT;

   a_r2_pend_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |=> ((ip & $past(irq)) == $past(irq)));

   a_r4_take_cond: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (boundary && ie[0] && (|(im & ip))));

   a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vector == eba + OFF && save_pc == pc));

   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (vector == '0 && save_pc == '0));

   a_r6_ie_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ie == 2'b10));

   a_r7_eret_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && !take) |=> (ie[0] == $past(ie[1]) && ie[1] == $past(ie[1])));

endmodule

bind vec_irq_unit irq_unit_chk #(
   .NLINES    (NLINES),
   .XLEN      (XLEN),
   .EXC_ID    (EXC_ID),
   .VEC_SHIFT (VEC_SHIFT)
) u_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .irq      (irq_i),
   .boundary (boundary_i),
   .eret     (eret_i),
   .take     (take_irq_o),
   .vector   (vector_pc_o),
   .save_pc  (save_pc_o),
   .pc       (pc_i),
   .ip       (ip_q),
   .im       (im_q),
   .ie       (ie_q),
   .eba      (eba_q)
);

// File: tb/tb_vec_irq_unit.sv
module tb_vec_irq_unit;
   import irq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 32;
   localparam logic [31:0] BASE = 32'hABCD_1200;
   localparam logic [31:0] OFF  = 32'd192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq = '0;
   logic        boundary = 1'b0;
   logic [31:0] pc = '0;
   logic        eret = 1'b0;
   logic [1:0]  csr_sel = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        take;
   logic [31:0] vec;
   logic [31:0] spc;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_unit dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .irq_i       (irq),
      .boundary_i  (boundary),
      .pc_i        (pc),
      .eret_i      (eret),
      .csr_sel_i   (csr_sel),
      .csr_we_i    (csr_we),
      .csr_wdata_i (csr_wdata),
      .csr_rdata_o (csr_rdata),
      .take_irq_o  (take),
      .vector_pc_o (vec),
      .save_pc_o   (spc)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic csr_wr(input logic [1:0] s, input logic [31:0] d);
      csr_sel = s;
      csr_wdata = d;
      csr_we = 1'b1;
      tick();
      csr_we = 1'b0;
   endtask

   task automatic csr_rd(input logic [1:0] s, output logic [31:0] d);
      csr_sel = s;
      #1;
      d = csr_rdata;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] exp;
      logic        hit;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      csr_rd(CSR_PEND, rd); chk(rd, 32'h0, "R1 pending");
      csr_rd(CSR_MASK, rd); chk(rd, 32'h0, "R1 mask");
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h0, "R1 enable");
      csr_rd(CSR_BASE, rd); chk(rd, 32'h0, "R1 base");
      chk({31'b0, take}, 32'h0, "R1 take");

      // R10: register map and field widths
      csr_wr(CSR_MASK, 32'hFFFF_FFFF);
      csr_rd(CSR_MASK, rd); chk(rd, 32'hFFFF_FFFF, "R10 mask rw");
      csr_wr(CSR_ENAB, 32'hFFFF_FFFF);
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h3, "R10 enable width");
      csr_wr(CSR_BASE, 32'hFFFF_FFFF);
      csr_rd(CSR_BASE, rd); chk(rd, 32'hFFFF_FF00, "R10 base align");
      csr_wr(CSR_MASK, 32'h0);
      csr_wr(CSR_ENAB, 32'h0);
      boundary = 1'b1; #1;
      chk({31'b0, take}, 32'h0, "R4 disabled boundary");
      tick();
      boundary = 1'b0;

      // R2: sticky pending, every line
      exp = '0;
      for (int m = 0; m < NL; m++) begin
         irq = 32'd1 << m;
         tick();
         irq = '0;
         tick();
         exp |= 32'd1 << m;
         csr_rd(CSR_PEND, rd); chk(rd, exp, "R2 sticky pending");
      end

      // R3: write-one-to-clear, partial then full
      csr_wr(CSR_PEND, 32'h5555_5555);
      csr_rd(CSR_PEND, rd); chk(rd, 32'hAAAA_AAAA, "R3 partial clear");
      csr_wr(CSR_PEND, 32'hFFFF_FFFF);
      csr_rd(CSR_PEND, rd); chk(rd, 32'h0, "R3 full clear");
      irq = 32'd1 << 7;
      tick();
      csr_wr(CSR_PEND, 32'd1 << 7);
      csr_rd(CSR_PEND, rd); chk(rd, 32'd1 << 7, "R3 held line resets bit");
      irq = '0;
      tick();
      boundary = 1'b1; tick(); boundary = 1'b0;
      csr_wr(CSR_PEND, 32'hFFFF_FFFF);
      csr_rd(CSR_PEND, rd); chk(rd, 32'h0, "R3 clear after drop");

      // R4 R5 R6 R9: mask bit against pulsed line sweep
      csr_wr(CSR_BASE, BASE);
      for (int n = 0; n < NL; n++) begin
         for (int m = 0; m < NL; m++) begin
            hit = (n == m);
            csr_wr(CSR_PEND, 32'hFFFF_FFFF);
            csr_wr(CSR_MASK, 32'd1 << n);
            csr_wr(CSR_ENAB, 32'h1);
            irq = 32'd1 << m;
            tick();
            irq = '0;
            boundary = 1'b1;
            pc = 32'h0001_0000 + 32'(n * 256 + m * 4);
            #1;
            chk({31'b0, take}, {31'b0, hit}, "R4 take sweep");
            chk(vec, hit ? BASE + OFF : 32'h0, "R5 vector");
            chk(spc, hit ? pc : 32'h0, "R5 save pc");
            tick();
            boundary = 1'b0;
            csr_rd(CSR_ENAB, rd);
            chk(rd, hit ? 32'h2 : 32'h1, "R6 enable after boundary");
            if (!hit) begin
               csr_wr(CSR_MASK, (32'd1 << n) | (32'd1 << m));
               boundary = 1'b1; #1;
               chk({31'b0, take}, 32'h0, "R9 spent check stays quiet");
               tick();
               boundary = 1'b0;
            end
         end
      end

      // R8: held line re-checked until mask opens
      csr_wr(CSR_PEND, 32'hFFFF_FFFF);
      csr_wr(CSR_MASK, 32'h0);
      csr_wr(CSR_ENAB, 32'h1);
      irq = 32'd1 << 5;
      tick();
      for (int k = 0; k < 3; k++) begin
         boundary = 1'b1; #1;
         chk({31'b0, take}, 32'h0, "R8 masked held line");
         tick();
      end
      boundary = 1'b0;
      csr_wr(CSR_MASK, 32'd1 << 5);
      boundary = 1'b1; pc = 32'h0000_4444; #1;
      chk({31'b0, take}, 32'h1, "R8 release after mask write");
      chk(spc, 32'h0000_4444, "R5 save pc held line");
      tick();
      boundary = 1'b0;
      irq = '0;
      tick();

      // R4: enable bit clear, and no boundary
      csr_wr(CSR_ENAB, 32'h0);
      irq = 32'd1 << 5; tick(); irq = '0;
      boundary = 1'b1; #1;
      chk({31'b0, take}, 32'h0, "R4 live enable off");
      tick(); boundary = 1'b0;
      csr_wr(CSR_ENAB, 32'h1);
      irq = 32'd1 << 5;
      tick(); tick(); #1;
      chk({31'b0, take}, 32'h0, "R4 no boundary");
      boundary = 1'b1; #1;
      chk({31'b0, take}, 32'h1, "R4 boundary arrives");
      // R6: take wins over enable write in same cycle
      csr_sel = CSR_ENAB; csr_wdata = 32'h1; csr_we = 1'b1;
      tick();
      csr_we = 1'b0; boundary = 1'b0; irq = '0;
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h2, "R6 take beats write");

      // R7: return restores live enable
      tick();
      eret = 1'b1; tick(); eret = 1'b0;
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h3, "R7 restore from saved 1");
      csr_wr(CSR_ENAB, 32'h1);
      eret = 1'b1; tick(); eret = 1'b0;
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h0, "R7 restore from saved 0");
      csr_wr(CSR_ENAB, 32'h2);
      eret = 1'b1; csr_sel = CSR_ENAB; csr_wdata = 32'h0; csr_we = 1'b1;
      tick();
      eret = 1'b0; csr_we = 1'b0;
      csr_rd(CSR_ENAB, rd); chk(rd, 32'h3, "R7 eret beats write");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule